// File: doc/BRIEF.md
# Filtered Multi-Input Fault Detector

This block guards a timer or PWM engine against external fault conditions. It watches four asynchronous fault pins and gives each one its own sticky flag. It also drives one combined flag that is high whenever any per-pin flag is set. Each pin passes through four stages in order:

- a two-flop synchronizer;
- an optional digital glitch filter;
- a polarity selector;
- a rising-edge detector that sets the pin's flag.

Detection runs only when the two-bit global mode field is nonzero, and only for pins whose enable bit is high.

The glitch filter is a small state machine with two states:

- `FLT_HOLD`: the accepted level matches the synchronized pin.
- `FLT_WATCH`: a new level is waiting to be confirmed.

It has four transitions:

- *start*: `FLT_HOLD` to `FLT_WATCH` when the synchronized pin differs from the accepted level.
- *revert*: `FLT_WATCH` to `FLT_HOLD` when the pin returns to the accepted level before confirmation. The counter is cleared.
- *accept*: `FLT_WATCH` to `FLT_HOLD` when the counter, incremented on a filter tick, exceeds the shared threshold. The accepted level takes the new value.
- *bypass*: any state to `FLT_HOLD` while the filter is bypassed.

Filter ticks come from a free-running prescaler. It emits a one-cycle pulse every 2^PS system clocks, where PS is the 4-bit prescaler select. Software clears each flag with a per-pin clear strobe.

Top module: `fault_guard`

## Requirements
- R1: After reset every per-pin flag and the combined flag are 0.
- R2: With the filter bypassed, a pin that goes active just before a rising clock edge sets its flag on the third rising edge, and the flag is still clear after the second.
- R3: The filter is bypassed whenever the pin's filter-enable bit is 0 or the shared threshold is 0.
- R4: With the filter active and PS=0 (a tick on every clock), a pin held active sets its flag on rising edge F+5 after it changes, where F is the threshold. The flag is still clear after edge F+4.
- R5: With the filter active, an active pulse of F·2^PS+1 clocks or less never sets the flag. A pulse of (F+1)·2^PS+1 clocks or more always sets it.
- R6: When a pin's polarity bit is 1, the pin is active-low: a falling pin sets the flag and a rising pin does not.
- R7: While the mode field is 2'b00 no flag is set, and enabling the mode while a pin is already active does not set a flag.
- R8: A pin whose enable bit is 0 never sets its flag.
- R9: A flag stays at 1 until its clear strobe is high for a clock, and then reads 0.
- R10: A fault edge in the same cycle as that pin's clear strobe leaves the flag at 1.
- R11: The combined output equals the OR of the four per-pin flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_pin | input | 4 | Raw asynchronous fault pins |
| fault_mode | input | 2 | Global detection mode, nonzero enables detection |
| in_en | input | 4 | Per-pin detection enable |
| filt_en | input | 4 | Per-pin glitch filter enable |
| pol_inv | input | 4 | Per-pin polarity, 1 = active-low |
| filt_val | input | 4 | Shared filter threshold F |
| psc_sel | input | 4 | Prescaler select PS, tick every 2^PS clocks |
| flag_clr | input | 4 | Per-pin flag clear strobe |
| fault_flag | output | 4 | Sticky per-pin fault flags |
| fault_any | output | 1 | OR of all per-pin flags |

## Verification
The bench times flag arrival to the exact edge in bypass mode and across every threshold at PS=0. A design with one synchronizer flop too many or too few, or a filter counter that is off by one, sets the flag one cycle early or late. The bench sweeps thresholds and prescaler settings with pulses just inside and just outside the glitch window. A filter that does not clear its counter on a reversion, or that compares with >= instead of >, either passes a glitch or drops a valid fault. It also drives a clear strobe that coincides with a new edge, which catches a design that gives the clear priority. It enables the mode while a pin is already active, which catches a design that treats the mode itself as an edge.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;
    typedef enum logic {
        FLT_HOLD  = 1'b0,
        FLT_WATCH = 1'b1
    } flt_state_e;
endpackage

// File: rtl/fg_prescaler.sv
module fg_prescaler #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);
    localparam int DIV_W = (2 ** PS_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_mask;

    always_comb begin
        div_mask = ~({DIV_W{1'b1}} << sel);
        tick     = ((div_cnt & div_mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fg_glitch_filter.sv
module fg_glitch_filter
    import fault_guard_pkg::*;
#(
    parameter int VAL_W = 4,
    parameter int CNT_W = VAL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             tick,
    input  logic             bypass,
    input  logic [VAL_W-1:0] thresh,
    output logic             dout
);
    flt_state_e       state_q;
    flt_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             held_q;
    logic             accept;

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        accept  = tick && (cnt_inc > CNT_W'(thresh));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_HOLD: begin
                if (!bypass && (din != held_q)) begin
                    state_d = FLT_WATCH;
                end
            end
            FLT_WATCH: begin
                if (bypass || (din == held_q)) begin
                    state_d = FLT_HOLD;
                end else if (accept) begin
                    state_d = FLT_HOLD;
                end
            end
            default: state_d = FLT_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else if (bypass) begin
            held_q <= din;
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                FLT_HOLD: cnt_q <= '0;
                FLT_WATCH: begin
                    if (din == held_q) begin
                        cnt_q <= '0;
                    end else if (accept) begin
                        held_q <= din;
                        cnt_q  <= '0;
                    end else if (tick) begin
                        cnt_q <= cnt_inc;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign dout = bypass ? din : held_q;
endmodule

// File: rtl/fg_channel.sv
module fg_channel #(
    parameter int VAL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             tick,
    input  logic             mode_on,
    input  logic             en,
    input  logic             fen,
    input  logic             pol,
    input  logic [VAL_W-1:0] thresh,
    input  logic             clr,
    output logic             held,
    output logic             byp,
    output logic             flag
);
    logic [1:0] sync_q;
    logic       filt_out;
    logic       act;
    logic       act_prev_q;
    logic       rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], pin};
        end
    end

    assign byp = !fen || (thresh == '0);

    fg_glitch_filter #(.VAL_W(VAL_W)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (sync_q[1]),
        .tick   (tick),
        .bypass (byp),
        .thresh (thresh),
        .dout   (filt_out)
    );

    assign held = filt_out;
    assign act  = filt_out ^ pol;
    assign rise = act && !act_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_prev_q <= 1'b0;
            flag       <= 1'b0;
        end else begin
            act_prev_q <= act;
            if (mode_on && en && rise) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fault_guard.sv
module fault_guard #(
    parameter int N_IN  = 4,
    parameter int VAL_W = 4,
    parameter int PS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  fault_pin,
    input  logic [1:0]       fault_mode,
    input  logic [N_IN-1:0]  in_en,
    input  logic [N_IN-1:0]  filt_en,
    input  logic [N_IN-1:0]  pol_inv,
    input  logic [VAL_W-1:0] filt_val,
    input  logic [PS_W-1:0]  psc_sel,
    input  logic [N_IN-1:0]  flag_clr,
    output logic [N_IN-1:0]  fault_flag,
    output logic             fault_any
);
    logic            tick_w;
    logic            mode_on;
    logic [N_IN-1:0] held_w;
    logic [N_IN-1:0] byp_w;

    assign mode_on = (fault_mode != 2'b00);

    fg_prescaler #(.PS_W(PS_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (psc_sel),
        .tick  (tick_w)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_ch
        fg_channel #(.VAL_W(VAL_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (fault_pin[g]),
            .tick    (tick_w),
            .mode_on (mode_on),
            .en      (in_en[g]),
            .fen     (filt_en[g]),
            .pol     (pol_inv[g]),
            .thresh  (filt_val),
            .clr     (flag_clr[g]),
            .held    (held_w[g]),
            .byp     (byp_w[g]),
            .flag    (fault_flag[g])
        );
    end

    assign fault_any = |fault_flag;
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
    parameter int N_IN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      fault_mode,
    input logic [N_IN-1:0] in_en,
    input logic [N_IN-1:0] flag_clr,
    input logic [N_IN-1:0] fault_flag,
    input logic [N_IN-1:0] held,
    input logic [N_IN-1:0] byp,
    input logic            tick
);
    for (genvar i = 0; i < N_IN; i++) begin : g_a
        a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_flag[i] && !flag_clr[i]) |=> fault_flag[i]);

        a_r7_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_mode == 2'b00 && !fault_flag[i]) |=> !fault_flag[i]);

        a_r8_input_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_en[i] && !fault_flag[i]) |=> !fault_flag[i]);

        a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
            (!byp[i] && !$past(byp[i]) && !$stable(held[i])) |-> $past(tick));
    end
endmodule

bind fault_guard fault_guard_chk #(.N_IN(N_IN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_mode (fault_mode),
    .in_en      (in_en),
    .flag_clr   (flag_clr),
    .fault_flag (fault_flag),
    .held       (held_w),
    .byp        (byp_w),
    .tick       (tick_w)
);

// File: tb/fault_guard_test.sv
module fault_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fault_pin = '0;
    logic [1:0] fault_mode = '0;
    logic [3:0] in_en = '0;
    logic [3:0] filt_en = '0;
    logic [3:0] pol_inv = '0;
    logic [3:0] filt_val = '0;
    logic [3:0] psc_sel = '0;
    logic [3:0] flag_clr = '0;
    logic [3:0] fault_flag;
    logic       fault_any;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fault_guard uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_pin  (fault_pin),
        .fault_mode (fault_mode),
        .in_en      (in_en),
        .filt_en    (filt_en),
        .pol_inv    (pol_inv),
        .filt_val   (filt_val),
        .psc_sel    (psc_sel),
        .flag_clr   (flag_clr),
        .fault_flag (fault_flag),
        .fault_any  (fault_any)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] md, input logic [3:0] en, input logic [3:0] fe,
                         input logic [3:0] pol, input logic [3:0] fv, input logic [3:0] ps);
        fault_mode = 2'b00;
        in_en      = en;
        filt_en    = fe;
        pol_inv    = pol;
        filt_val   = fv;
        psc_sel    = ps;
        fault_pin  = pol;
        cyc(300);
        flag_clr = 4'hF;
        cyc(1);
        flag_clr = 4'h0;
        fault_mode = md;
        cyc(1);
    endtask

    initial begin
        cyc(200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1: reset state
        chk("R1", {fault_any, fault_flag}, 5'b0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1", {fault_any, fault_flag}, 5'b0);

        // R2: bypass latency on each pin
        for (int p = 0; p < 4; p++) begin
            setup(2'b01, 4'hF, 4'h0, 4'h0, 4'd5, 4'd0);
            fault_pin[p] = 1'b1;
            cyc(2);
            chk("R2 early", {1'b0, fault_flag}, 5'b0);
            cyc(1);
            chk("R2 edge3", {1'b0, fault_flag}, {1'b0, 4'(1 << p)});
        end

        // R3: filter enabled but threshold zero still bypasses
        setup(2'b10, 4'hF, 4'hF, 4'h0, 4'd0, 4'd0);
        fault_pin[2] = 1'b1;
        cyc(2);
        chk("R3 early", {1'b0, fault_flag}, 5'b0);
        cyc(1);
        chk("R3 edge3", {1'b0, fault_flag}, 5'b00100);

        // R4: filtered latency for every threshold, PS=0
        for (int f = 1; f < 16; f++) begin
            setup(2'b11, 4'hF, 4'hF, 4'h0, 4'(f), 4'd0);
            fault_pin[1] = 1'b1;
            cyc(f + 4);
            chk("R4 early", {1'b0, fault_flag}, 5'b0);
            cyc(1);
            chk("R4 on time", {1'b0, fault_flag}, 5'b00010);
        end

        // R5: glitch window sweep over prescaler and threshold
        for (int ps = 0; ps < 3; ps++) begin
            for (int f = 1; f < 7; f++) begin
                setup(2'b01, 4'hF, 4'hF, 4'h0, 4'(f), 4'(ps));
                fault_pin[0] = 1'b1;
                cyc(f * (1 << ps) + 1);
                fault_pin[0] = 1'b0;
                cyc(120);
                chk("R5 glitch dropped", {1'b0, fault_flag}, 5'b0);
                fault_pin[0] = 1'b1;
                cyc((f + 1) * (1 << ps) + 1);
                fault_pin[0] = 1'b0;
                cyc(120);
                chk("R5 pulse kept", {1'b0, fault_flag}, 5'b00001);
            end
        end

        // R6: active-low pin
        setup(2'b01, 4'hF, 4'h0, 4'b1000, 4'd0, 4'd0);
        chk("R6 idle high", {1'b0, fault_flag}, 5'b0);
        fault_pin[3] = 1'b0;
        cyc(3);
        chk("R6 falling sets", {1'b0, fault_flag}, 5'b01000);
        setup(2'b01, 4'hF, 4'h0, 4'b1000, 4'd0, 4'd0);
        fault_pin[3] = 1'b0;
        cyc(10);
        flag_clr = 4'hF;
        cyc(1);
        flag_clr = 4'h0;
        fault_pin[3] = 1'b1;
        cyc(10);
        chk("R6 rising ignored", {1'b0, fault_flag}, 5'b0);

        // R7: mode zero, then enabling the mode while active
        setup(2'b00, 4'hF, 4'h0, 4'h0, 4'd0, 4'd0);
        fault_pin = 4'hF;
        cyc(10);
        chk("R7 mode off", {fault_any, fault_flag}, 5'b0);
        fault_mode = 2'b01;
        cyc(10);
        chk("R7 mode on level", {fault_any, fault_flag}, 5'b0);

        // R8: disabled pin
        setup(2'b01, 4'b1101, 4'h0, 4'h0, 4'd0, 4'd0);
        fault_pin = 4'hF;
        cyc(10);
        chk("R8 disabled pin", {1'b0, fault_flag}, 5'b01101);

        // R9: sticky and clear
        setup(2'b01, 4'hF, 4'h0, 4'h0, 4'd0, 4'd0);
        fault_pin[1] = 1'b1;
        cyc(3);
        fault_pin[1] = 1'b0;
        cyc(50);
        chk("R9 sticky", {1'b0, fault_flag}, 5'b00010);
        flag_clr[1] = 1'b1;
        cyc(1);
        flag_clr[1] = 1'b0;
        chk("R9 cleared", {1'b0, fault_flag}, 5'b0);

        // R10: new edge in the clear cycle wins
        setup(2'b01, 4'hF, 4'h0, 4'h0, 4'd0, 4'd0);
        fault_pin[2] = 1'b1;
        cyc(3);
        fault_pin[2] = 1'b0;
        cyc(10);
        fault_pin[2] = 1'b1;
        cyc(2);
        flag_clr[2] = 1'b1;
        cyc(1);
        flag_clr[2] = 1'b0;
        chk("R10 set wins", {1'b0, fault_flag}, 5'b00100);

        // R11: combined flag, all pin patterns
        for (int m = 0; m < 16; m++) begin
            setup(2'b01, 4'hF, 4'h0, 4'h0, 4'd0, 4'd0);
            fault_pin = 4'(m);
            cyc(4);
            chk("R11 or", {fault_any, fault_flag}, {(m != 0), 4'(m)});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule